// File: doc/BRIEF.md
# Port Pin Edge-Interrupt Controller

This block watches up to 32 asynchronous port pins. Each pin first passes through a two-flop synchroniser. An edge detector then follows, and a per-line sense bit sets it either to falling edges only or to both edge directions. A detected edge sets a sticky bit in an event register. All enabled pending events are combined into one interrupt request towards a host interrupt controller.

Software sees three 32-bit registers through a plain read/write strobe port. The event register is at offset 0x0C, the mask register at 0x10 and the sense-control register at 0x14. Line n is held in register bit (31 − n), so line 0 is the most significant bit. To find the line to service, the host reads the event register and takes the lowest-order set bit, which is the highest-numbered pending line. It then clears that bit by writing a one to it.

Top module: `port_edge_irq`

## Requirements
- R1: After reset the event, mask and control registers read as zero and `irqOut` is low.
- R2: The event register is at address 0x0C, the mask at 0x10 and the control at 0x14. A read from any other address returns zero, and a write to any other address changes no register.
- R3: Pin `pinIn[n]` drives register bit (31 − n) of the event, mask and control registers, so line 0 is bit 31 and line 31 is bit 0.
- R4: With control bit (31 − n) at 1, a rising edge on line n leaves its event bit clear, and a falling edge sets it.
- R5: With control bit (31 − n) at 0, both a rising and a falling edge on line n set its event bit.
- R6: An edge sets its event bit even when the line's mask bit is 0. `irqOut` is high exactly while (event AND mask) is nonzero, and a mask bit of 1 enables the line.
- R7: A write to the event register clears each bit written with 1 and leaves each bit written with 0 unchanged. Writes to the mask and control registers load the written value.
- R8: If an edge sets an event bit on the same clock edge as a write clears that bit, the bit stays set.
- R9: Read data appears on `rdData` one cycle after the clock edge that samples `rdEn`. A read in the same cycle as a write to the same register returns the value from before the write.
- R10: Suppose a pin change is first sampled at clock edge k. The event bit is then set at edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | NUM_LINES | Raw port pins; bit n is line n |
| wrEn | input | 1 | Write strobe, taken on the rising clock edge |
| rdEn | input | 1 | Read strobe, taken on the rising clock edge |
| addr | input | ADDR_W | Register byte offset |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data, held between reads |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A pin change driven between clock edges shows in the event register after three rising edges: two synchroniser stages, then the event flop. The bench therefore samples `irqOut` after the second edge, expecting low, and again after the third edge, expecting high. Read data is due one edge after `rdEn`, so the monitor compares it at the falling edge that follows the capturing edge. Register writes and the resulting `irqOut` change take effect at the write edge, so those checks are made half a cycle later. The set-versus-clear case lines up a write strobe with edge k+2 of a pin change.

// File: rtl/port_edge_irq_pkg.sv
package port_edge_irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_MSK  = 2'd2,
    SEL_CTL  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    clrEvt;
    logic    ldMsk;
    logic    ldCtl;
    logic    rdHit;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= rawIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/port_edge_irq_ctrl.sv
module port_edge_irq_ctrl
  import port_edge_irq_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  EVT_OFS = 8'h0C,
  parameter logic [7:0]  MSK_OFS = 8'h10,
  parameter logic [7:0]  CTL_OFS = 8'h14
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strb
);

  localparam logic [ADDR_W-1:0] EVT_A = ADDR_W'(EVT_OFS);
  localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFS);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);

  logic hitEvt, hitMsk, hitCtl;

  assign hitEvt = (addr == EVT_A);
  assign hitMsk = (addr == MSK_A);
  assign hitCtl = (addr == CTL_A);

  always_comb begin
    strb        = '0;
    strb.clrEvt = wrEn & hitEvt;
    strb.ldMsk  = wrEn & hitMsk;
    strb.ldCtl  = wrEn & hitCtl;
    strb.rdHit  = rdEn;
    if (hitEvt)      strb.rdSel = SEL_EVT;
    else if (hitMsk) strb.rdSel = SEL_MSK;
    else if (hitCtl) strb.rdSel = SEL_CTL;
    else             strb.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/port_edge_irq_dp.sv
module port_edge_irq_dp
  import port_edge_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int SYNC_STG  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic [DATA_W-1:0]    wrData,
  input  ctrlStrobes_t         strb,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut
);

  localparam int SPARE = DATA_W - NUM_LINES;

  function automatic logic [DATA_W-1:0] liveBits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_LINES; n++) m[DATA_W-1-n] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] LIVE = liveBits();

  logic [NUM_LINES-1:0] syncLvl, prevLvl;
  logic [DATA_W-1:0]    setVec;
  logic [DATA_W-1:0]    evtReg, mskReg, ctlReg;
  logic [DATA_W-1:0]    evtNext;

  line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (pinIn),
    .syncOut(syncLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncLvl;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int BIT = DATA_W - 1 - n;
    logic riseHit, fallHit;
    assign riseHit     = syncLvl[n] & ~prevLvl[n];
    assign fallHit     = ~syncLvl[n] & prevLvl[n];
    assign setVec[BIT] = fallHit | (riseHit & ~ctlReg[BIT]);
  end

  for (genvar b = 0; b < SPARE; b++) begin : g_spare
    assign setVec[b] = 1'b0;
  end

  assign evtNext = strb.clrEvt ? ((evtReg & ~wrData) | setVec) : (evtReg | setVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtReg <= '0;
      mskReg <= '0;
      ctlReg <= '0;
    end else begin
      evtReg <= evtNext & LIVE;
      if (strb.ldMsk) mskReg <= wrData & LIVE;
      if (strb.ldCtl) ctlReg <= wrData & LIVE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdHit) begin
      unique case (strb.rdSel)
        SEL_EVT: rdData <= evtReg;
        SEL_MSK: rdData <= mskReg;
        SEL_CTL: rdData <= ctlReg;
        default: rdData <= '0;
      endcase
    end
  end

  assign irqOut = |(evtReg & mskReg);

endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
  import port_edge_irq_pkg::*;
#(
  parameter int         NUM_LINES = 32,
  parameter int         DATA_W    = 32,
  parameter int         ADDR_W    = 8,
  parameter int         SYNC_STG  = 2,
  parameter logic [7:0] EVT_OFS   = 8'h0C,
  parameter logic [7:0] MSK_OFS   = 8'h10,
  parameter logic [7:0] CTL_OFS   = 8'h14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut
);

  ctrlStrobes_t strb;

  port_edge_irq_ctrl #(
    .ADDR_W (ADDR_W),
    .EVT_OFS(EVT_OFS),
    .MSK_OFS(MSK_OFS),
    .CTL_OFS(CTL_OFS)
  ) u_ctrl (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .strb(strb)
  );

  port_edge_irq_dp #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W),
    .SYNC_STG (SYNC_STG)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn (pinIn),
    .wrData(wrData),
    .strb  (strb),
    .rdData(rdData),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/port_edge_irq_chk.sv
module port_edge_irq_chk #(
  parameter int         NUM_LINES = 32,
  parameter int         DATA_W    = 32,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] EVT_OFS   = 8'h0C,
  parameter logic [7:0] MSK_OFS   = 8'h10,
  parameter logic [7:0] CTL_OFS   = 8'h14
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] pinIn,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic                 irqOut
);

  logic [DATA_W-1:0]    shadowMsk;
  logic [NUM_LINES-1:0] lastPin;
  logic [1:0]           quietCnt;
  logic                 mappedAddr;

  assign mappedAddr = (addr == ADDR_W'(EVT_OFS)) || (addr == ADDR_W'(MSK_OFS)) ||
                      (addr == ADDR_W'(CTL_OFS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowMsk <= '0;
      lastPin   <= '0;
      quietCnt  <= '0;
    end else begin
      if (wrEn && addr == ADDR_W'(MSK_OFS)) shadowMsk <= wrData;
      lastPin <= pinIn;
      if (pinIn != lastPin)   quietCnt <= '0;
      else if (quietCnt != 2'd3) quietCnt <= quietCnt + 2'd1;
    end
  end

  // R9: mask read returns the value held before the read edge
  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(MSK_OFS)) |=> (rdData == $past(shadowMsk)));

  // R2: unmapped reads return zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mappedAddr) |=> (rdData == '0));

  // R6: a request needs at least one enabled line
  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (shadowMsk != '0));

  // R7: clearing every bit with pins quiet drops the request
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(EVT_OFS) && wrData == '1 && quietCnt == 2'd3) |=> !irqOut);

endmodule

bind port_edge_irq port_edge_irq_chk #(
  .NUM_LINES(NUM_LINES),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .EVT_OFS  (EVT_OFS),
  .MSK_OFS  (MSK_OFS),
  .CTL_OFS  (CTL_OFS)
) u_chk (.*);

// File: tb/tb_port_edge_irq.sv
module tb_port_edge_irq;

  localparam logic [7:0] A_EVT = 8'h0C;
  localparam logic [7:0] A_MSK = 8'h10;
  localparam logic [7:0] A_CTL = 8'h14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;
  int          cycles = 0;

  always #2.5 clk = ~clk;

  port_edge_irq dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] lineBit(int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic note(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    rdEn = 1'b1; addr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic chkIrq(logic exp, string tag);
    note(tag, {31'd0, irqOut}, {31'd0, exp});
  endtask

  // monitor: read data is due one edge after rdEn is taken
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        note("unexpected read", rdData, 32'hx);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        note(t, rdData, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    chkIrq(1'b0, "R1 irq after reset");
    rd(A_EVT, 32'h0, "R1 event reset");
    rd(A_MSK, 32'h0, "R1 mask reset");
    rd(A_CTL, 32'h0, "R1 control reset");

    wr(A_MSK, 32'hFFFF_FFFF);
    rd(A_MSK, 32'hFFFF_FFFF, "R7 mask load");
    wr(A_CTL, 32'h0);

    // rising edge on line 0, both-edge sensing
    pinIn[0] = 1'b1;
    tick(2);
    chkIrq(1'b0, "R10 not yet at k+1");
    tick(1);
    chkIrq(1'b1, "R10 set at k+2");
    rd(A_EVT, lineBit(0), "R3 R5 line0 rise at bit31");

    wr(A_EVT, 32'h7FFF_FFFF);
    rd(A_EVT, lineBit(0), "R7 zero bits keep event");
    wr(A_EVT, lineBit(0));
    chkIrq(1'b0, "R7 irq after clear");
    rd(A_EVT, 32'h0, "R7 one clears event");

    pinIn[0] = 1'b0;
    tick(4);
    rd(A_EVT, lineBit(0), "R5 falling edge sets");
    wr(A_EVT, 32'hFFFF_FFFF);

    // falling-only on line 5
    wr(A_CTL, lineBit(5));
    rd(A_CTL, 32'h0400_0000, "R3 control bit26 for line5");
    pinIn[5] = 1'b1;
    tick(4);
    rd(A_EVT, 32'h0, "R4 rise ignored");
    chkIrq(1'b0, "R4 irq stays low");
    pinIn[5] = 1'b0;
    tick(4);
    rd(A_EVT, 32'h0400_0000, "R4 fall sets");
    wr(A_EVT, 32'hFFFF_FFFF);

    // masked line 31 still latches
    wr(A_MSK, 32'h0);
    pinIn[31] = 1'b1;
    tick(4);
    chkIrq(1'b0, "R6 masked no irq");
    rd(A_EVT, 32'h0000_0001, "R6 R3 line31 latched at bit0");
    wr(A_MSK, 32'h0000_0001);
    chkIrq(1'b1, "R6 unmask raises irq");
    wr(A_EVT, 32'h0000_0001);
    chkIrq(1'b0, "R6 irq after clear");

    // set wins over same-edge clear, line 7 at bit 24
    pinIn[7] = 1'b1;
    tick(2);
    wr(A_EVT, 32'h0100_0000);
    rd(A_EVT, 32'h0100_0000, "R8 set wins over clear");
    wr(A_EVT, 32'h0100_0000);
    rd(A_EVT, 32'h0, "R8 later clear works");

    // unmapped addresses
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R2 unmapped read 0x00");
    rd(8'h18, 32'h0, "R2 unmapped read 0x18");
    rd(A_MSK, 32'h0000_0001, "R2 mask untouched");
    rd(A_CTL, lineBit(5), "R2 control untouched");

    // read and write in the same cycle
    wrEn = 1'b1; rdEn = 1'b1; addr = A_MSK; wrData = 32'hA5A5_0F0F;
    expQ.push_back(32'h0000_0001); tagQ.push_back("R9 read before write");
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    rd(A_MSK, 32'hA5A5_0F0F, "R9 read after write");

    tick(3);
    if (expQ.size() != 0) note("R9 reads left over", 32'(expQ.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule